// File: doc/BRIEF.md
# Host Access Bus Error Checker

This block sits between a host bus port and the internal memory space of a timing coprocessor. That space holds four regions: code memory, channel registers, time base registers and data memory. The block takes each host access, latches the access and the relevant control bits, and decides whether the access may reach its target. It then either ends the access normally or ends it with a bus error. The decision rests on two things. The first is a set of region-specific mode bits: a code visibility bit, a module-disable bit and a stop flag. The second is the uncorrectable-error flags from the ECC checkers of the code and data memories. Those flags count only for particular access directions and widths, and only while the matching detect-disable bit is clear.

A write to code memory that is narrower than the full word is handled as a read-modify-write. The block issues a background read strobe, and the ECC verdict of that read decides whether the write may go ahead. Whenever an error is returned, the write strobe to the target is held off, so no state changes.

The controller is a four-state machine. **IDLE** accepts a request (transition *accept*: `req_valid` while `req_ready`). **LOOKUP** drives the read strobe when the access needs a read and is not blocked (transition *probe*, always to CHECK). **CHECK** samples the ECC flags returned for that read and registers the verdict (transition *decide*, always to RESPOND). **RESPOND** raises the acknowledge for one cycle, together with the error or the write strobe (transition *retire*, back to IDLE).

Top module: `ehc_top`

## Requirements
- R1: Any access (read or write, any size) to code memory (region code 0) ends with `bus_err` while `code_vis` is 0.
- R2: Any access to channel registers (region code 1) ends with `bus_err` while `mod_dis` or `stop_flag` is 1.
- R3: A write to time base registers (region code 2) ends with `bus_err` while `mod_dis` or `stop_flag` is 1; a read of that region completes without error under the same bits.
- R4: A read of code memory of any size ends with `bus_err` when `code_ue` is 1 in the CHECK cycle and `code_edd` is 0; with `code_edd` at 1 the flag has no effect.
- R5: A code memory write narrower than a word (size code 0 = byte, 1 = halfword; 2 = word) issues one background read strobe, and ends with `bus_err` if `code_ue` is 1 and `code_edd` is 0. A word write issues no read strobe and ignores `code_ue`.
- R6: A read of data memory (region code 3) ends with `bus_err` when `data_ue` is 1 and `data_edd` is 0; writes to data memory ignore `data_ue`.
- R7: A write that ends with `bus_err` produces no `tgt_wr_stb`. A write without error produces exactly one `tgt_wr_stb`, in the acknowledge cycle.
- R8: Each accepted request yields exactly one single-cycle `ack`. `bus_err` is only ever high together with `ack`.
- R9: `ack` rises in the third cycle after the accepting clock edge. `req_ready` is low from acceptance until the cycle after `ack`, and requests presented while it is low are ignored.
- R10: After reset, `req_ready` is 1 and `ack`, `bus_err`, `tgt_rd_stb` and `tgt_wr_stb` are 0.
- R11: An access blocked by a mode bit (R1 to R3) issues no read strobe. A read that is not blocked issues exactly one `tgt_rd_stb`, in the LOOKUP cycle.
- R12: Control bits are sampled at acceptance; changes to them later in the access have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host presents an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_region | input | 2 | 0 code, 1 channel regs, 2 time base, 3 data |
| code_vis | input | 1 | Code memory visible to the host |
| mod_dis | input | 1 | Module disabled |
| stop_flag | input | 1 | Module stopped |
| code_edd | input | 1 | Code memory error detection disabled |
| data_edd | input | 1 | Data memory error detection disabled |
| code_ue | input | 1 | Code memory uncorrectable ECC error, valid in CHECK |
| data_ue | input | 1 | Data memory uncorrectable ECC error, valid in CHECK |
| req_ready | output | 1 | Block can accept an access |
| tgt_rd_stb | output | 1 | Read strobe to the target region |
| tgt_wr_stb | output | 1 | Write strobe to the target region |
| tgt_region | output | 2 | Region addressed by the current access |
| ack | output | 1 | Access completion, one cycle |
| bus_err | output | 1 | Access ends with a bus error |

## Verification
If an access is accepted on clock edge N, its read strobe is seen after edge N, the ECC flags are sampled on edge N+2, and `ack` with `bus_err` or the write strobe is seen after edge N+2. For every access, the driver pushes the due cycle, the error, the write-strobe value and the read-strobe count into a queue. The monitor samples on falling edges. It counts read strobes, and when `ack` appears it pops the queued item and checks the cycle number as well as the values. An acknowledge with an empty queue counts as a failure, which is how the ignored request during a busy access is caught.

// File: rtl/ehc_pkg.sv
package ehc_pkg;
    typedef enum logic [1:0] {
        REG_CODE  = 2'd0,
        REG_CHAN  = 2'd1,
        REG_TBASE = 2'd2,
        REG_DATA  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_LOOKUP  = 2'd1,
        S_CHECK   = 2'd2,
        S_RESPOND = 2'd3
    } state_e;

    typedef struct packed {
        logic       wr;
        logic [1:0] size;
        region_e    region;
        logic       code_vis;
        logic       mod_dis;
        logic       stop;
        logic       code_edd;
        logic       data_edd;
    } req_t;
endpackage

// File: rtl/ehc_mode_gate.sv
module ehc_mode_gate
    import ehc_pkg::*;
#(
    parameter int SIZE_W    = 2,
    parameter int FULL_SIZE = 2
) (
    input  req_t rq,
    output logic blocked,
    output logic need_read
);
    localparam logic [SIZE_W-1:0] FULL_CODE = SIZE_W'(FULL_SIZE);

    logic halted;
    logic narrow;

    always_comb begin
        halted  = rq.mod_dis | rq.stop;
        narrow  = (rq.size < FULL_CODE);
        blocked = 1'b0;
        unique case (rq.region)
            REG_CODE:  blocked = ~rq.code_vis;
            REG_CHAN:  blocked = halted;
            REG_TBASE: blocked = halted & rq.wr;
            REG_DATA:  blocked = 1'b0;
            default:   blocked = 1'b0;
        endcase
        // reads always fetch; sub-word code writes fetch for merge
        need_read = ~rq.wr | ((rq.region == REG_CODE) & narrow);
    end
endmodule

// File: rtl/ehc_ecc_qual.sv
module ehc_ecc_qual
    import ehc_pkg::*;
(
    input  req_t rq,
    input  logic fetched,
    input  logic code_ue,
    input  logic data_ue,
    output logic ecc_err
);
    logic code_hit;
    logic data_hit;

    always_comb begin
        code_hit = (rq.region == REG_CODE) & code_ue & ~rq.code_edd;
        data_hit = (rq.region == REG_DATA) & ~rq.wr & data_ue & ~rq.data_edd;
        ecc_err  = fetched & (code_hit | data_hit);
    end
endmodule

// File: rtl/ehc_top.sv
module ehc_top
    import ehc_pkg::*;
#(
    parameter int SIZE_W    = 2,
    parameter int FULL_SIZE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [1:0]        req_region,
    input  logic              code_vis,
    input  logic              mod_dis,
    input  logic              stop_flag,
    input  logic              code_edd,
    input  logic              data_edd,
    input  logic              code_ue,
    input  logic              data_ue,
    output logic              req_ready,
    output logic              tgt_rd_stb,
    output logic              tgt_wr_stb,
    output logic [1:0]        tgt_region,
    output logic              ack,
    output logic              bus_err
);
    state_e state_q, state_d;
    req_t   rq_q;
    logic   err_q;
    logic   blocked, need_read, fetch_ok, ecc_err;

    ehc_mode_gate #(.SIZE_W(SIZE_W), .FULL_SIZE(FULL_SIZE)) u_gate (
        .rq        (rq_q),
        .blocked   (blocked),
        .need_read (need_read)
    );

    assign fetch_ok = need_read & ~blocked;

    ehc_ecc_qual u_ecc (
        .rq      (rq_q),
        .fetched (fetch_ok),
        .code_ue (code_ue),
        .data_ue (data_ue),
        .ecc_err (ecc_err)
    );

    // state register and request/verdict capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rq_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && req_valid) begin
                rq_q.wr       <= req_write;
                rq_q.size     <= req_size;
                rq_q.region   <= region_e'(req_region);
                rq_q.code_vis <= code_vis;
                rq_q.mod_dis  <= mod_dis;
                rq_q.stop     <= stop_flag;
                rq_q.code_edd <= code_edd;
                rq_q.data_edd <= data_edd;
            end
            if (state_q == S_CHECK) begin
                err_q <= blocked | ecc_err;
            end
        end
    end

    // transitions: accept, probe, decide, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_LOOKUP;
            S_LOOKUP:  state_d = S_CHECK;
            S_CHECK:   state_d = S_RESPOND;
            S_RESPOND: state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        tgt_rd_stb = 1'b0;
        tgt_wr_stb = 1'b0;
        ack        = 1'b0;
        bus_err    = 1'b0;
        tgt_region = rq_q.region;
        unique case (state_q)
            S_IDLE:    req_ready  = 1'b1;
            S_LOOKUP:  tgt_rd_stb = fetch_ok;
            S_CHECK:   ;
            S_RESPOND: begin
                ack        = 1'b1;
                bus_err    = err_q;
                tgt_wr_stb = rq_q.wr & ~err_q;
            end
            default:   ;
        endcase
    end

    AST_ERR_ONLY_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ack); // R8
    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_NO_WRITE_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !tgt_wr_stb); // R7
    AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr_stb |-> ack); // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R9
    AST_HIDDEN_CODE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_stb |-> !(rq_q.region == REG_CODE && !rq_q.code_vis)); // R11
    AST_HIDDEN_CODE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && rq_q.region == REG_CODE && !rq_q.code_vis) |=> bus_err); // R1
    AST_READ_THEN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rd_stb |=> (!ack && !tgt_rd_stb)); // R9
endmodule

// File: tb/tb_ehc_top.sv
module tb_ehc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = '0, req_region = '0;
    logic code_vis = 1'b0, mod_dis = 1'b0, stop_flag = 1'b0;
    logic code_edd = 1'b0, data_edd = 1'b0, code_ue = 1'b0, data_ue = 1'b0;
    logic req_ready, tgt_rd_stb, tgt_wr_stb, ack, bus_err;
    logic [1:0] tgt_region;

    ehc_top dut (.*);

    always #5 clk = ~clk;

    typedef struct {
        int    due;
        logic  err;
        logic  wr;
        int    rds;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int rd_cnt = 0;
    int ack_cnt = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int expv, input string what);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (tgt_rd_stb) rd_cnt++;
            if (ack) begin
                ack_cnt++;
                if (exp_q.size() == 0) begin
                    check("R9", 1, 0, "unexpected ack");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(e.tag, cyc, e.due, "ack cycle");
                    check(e.tag, int'(bus_err), int'(e.err), "bus_err");
                    check(e.tag, int'(tgt_wr_stb), int'(e.wr), "wr strobe");
                    check(e.tag, rd_cnt, e.rds, "read strobes");
                end
                rd_cnt = 0;
            end
        end
    end

    task automatic access(input string tag, input logic wr, input logic [1:0] sz,
                          input logic [1:0] rg, input logic vis, input logic md,
                          input logic st, input logic cedd, input logic dedd,
                          input logic cue, input logic due);
        exp_t e;
        logic blk, nrd, rd, ecc;
        while (!req_ready) @(negedge clk);
        blk = (rg == 2'd0 && !vis) || (rg == 2'd1 && (md || st)) || (rg == 2'd2 && wr && (md || st));
        nrd = !wr || (rg == 2'd0 && sz < 2'd2);
        rd  = nrd && !blk;
        ecc = rd && ((rg == 2'd0 && cue && !cedd) || (rg == 2'd3 && !wr && due && !dedd));
        e.due = cyc + 3;
        e.err = blk || ecc;
        e.wr  = wr && !(blk || ecc);
        e.rds = rd ? 1 : 0;
        e.tag = tag;
        exp_q.push_back(e);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_region = rg;
        code_vis = vis; mod_dis = md; stop_flag = st; code_edd = cedd; data_edd = dedd;
        code_ue = cue; data_ue = due;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        code_ue = 1'b0; data_ue = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int acks_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", int'(req_ready), 1, "req_ready");
        check("R10", int'(ack), 0, "ack");
        check("R10", int'(bus_err), 0, "bus_err");
        check("R10", int'(tgt_rd_stb | tgt_wr_stb), 0, "strobes");

        // wr sz rg vis md st cedd dedd cue due
        access("R1", 0, 2, 0, 0, 0, 0, 0, 0, 0, 0);
        access("R1", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        access("R11", 0, 2, 0, 1, 0, 0, 0, 0, 0, 0);
        access("R2", 0, 1, 1, 1, 1, 0, 0, 0, 0, 0);
        access("R2", 1, 2, 1, 1, 0, 1, 0, 0, 0, 0);
        access("R7", 1, 2, 1, 1, 0, 0, 0, 0, 0, 0);
        access("R3", 1, 2, 2, 1, 1, 0, 0, 0, 0, 0);
        access("R3", 0, 2, 2, 1, 1, 1, 0, 0, 0, 0);
        access("R4", 0, 0, 0, 1, 0, 0, 0, 0, 1, 0);
        access("R4", 0, 2, 0, 1, 0, 0, 1, 0, 1, 0);
        access("R5", 1, 1, 0, 1, 0, 0, 0, 0, 1, 0);
        access("R5", 1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        access("R5", 1, 2, 0, 1, 0, 0, 0, 0, 1, 0);
        access("R6", 0, 2, 3, 1, 0, 0, 0, 0, 0, 1);
        access("R6", 1, 2, 3, 1, 0, 0, 0, 0, 0, 1);
        access("R6", 0, 2, 3, 1, 0, 0, 0, 1, 0, 1);
        access("R11", 1, 2, 2, 1, 0, 1, 0, 0, 1, 1);

        // R12: control bits change after acceptance
        begin
            exp_t e;
            while (!req_ready) @(negedge clk);
            e.due = cyc + 3; e.err = 1'b0; e.wr = 1'b1; e.rds = 0; e.tag = "R12";
            exp_q.push_back(e);
            req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_region = 2'd1;
            code_vis = 1'b1; mod_dis = 1'b0; stop_flag = 1'b0;
            @(negedge clk);
            req_valid = 1'b0; mod_dis = 1'b1; stop_flag = 1'b1;
            repeat (3) @(negedge clk);
            mod_dis = 1'b0; stop_flag = 1'b0;
        end

        // R9: request presented while busy is ignored
        acks_before = ack_cnt;
        begin
            exp_t e;
            while (!req_ready) @(negedge clk);
            e.due = cyc + 3; e.err = 1'b0; e.wr = 1'b0; e.rds = 1; e.tag = "R9";
            exp_q.push_back(e);
            req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_region = 2'd3;
            data_edd = 1'b0; data_ue = 1'b0;
            @(negedge clk);
            check("R9", int'(req_ready), 0, "ready while busy");
            req_region = 2'd1; mod_dis = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; mod_dis = 1'b0;
            repeat (8) @(negedge clk);
        end
        check("R9", ack_cnt - acks_before, 1, "ack count");
        check("R8", exp_q.size(), 0, "pending items");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule